// File: doc/BRIEF.md
# Configurable down-counting timer

A two-channel hardware timer for general event pacing. Each channel owns a down-counter that decrements once per clock while enabled. Software selects, per channel, whether the counter is 16 or 32 bits wide. It also selects one of three behaviours at zero:
- restart from the all-ones value of the chosen width (free-running, the reset choice);
- restart from a software-loaded value (periodic);
- halt and disarm itself (one-shot).

Every arrival at zero sets a sticky per-channel event flag. Each flag drives its own interrupt line through a per-channel mask.

Software reaches the timer over a plain synchronous register bus with a write strobe and a read strobe. The address is `{channel, reg}`, with a 3-bit register index:

| Index | Register | Access |
|---|---|---|
| 0 | load | read/write |
| 1 | control | read/write |
| 2 | current count | read only |
| 3 | event status | read only |
| 4 | event clear | write 1 to bit 0 |

The control word has these fields:
- bit 0: run enable;
- bits 2:1: mode, where 00 is free-running, 01 is periodic, and 10 or 11 is one-shot;
- bit 3: width, where 1 selects 32 bits and 0 selects 16 bits;
- bit 4: interrupt pass (1 lets the flag reach the line).

Any write to control restarts the counter:
- free-running restarts from all-ones;
- the other modes restart from the load value.

A tick is the clock edge at which an enabled channel either decrements or, holding zero, takes its zero event.

Top module: `cfg_down_timer`

## Requirements
- R1: After reset every channel reads control 0 (disabled, free-running, 16-bit, masked), count 0x0000FFFF and status 0, and every interrupt line is low.
- R2: In free-running mode an enabled channel counts down to 0, and on the next tick sets its status and restarts from all-ones of its width.
- R3: With the width bit set, free-running starts from 0xFFFFFFFF and counts across all 32 bits.
- R4: With the width bit clear, only the low 16 bits of a load value reach the counter and the upper 16 count bits read zero.
- R5: In periodic mode a channel holding 0 sets its status on the next tick and restarts from its load value, giving a period of load+1 ticks.
- R6: In periodic or one-shot mode a load write restarts the count from the new value at that write's edge, whether or not the channel runs.
- R7: Status is sticky until a write of 1 to bit 0 of the clear register; a zero event in the same cycle as such a clear leaves status set.
- R8: Each interrupt line is high exactly when that channel's status is set and its interrupt-pass bit is 1, updated at the same edge as the status.
- R9: In free-running mode a load write does not disturb the running count.
- R10: A load value of 0 in periodic mode raises the event on the first tick and again on every tick after it.
- R11: In one-shot mode (mode 10 or 11) a channel reaching 0 sets status, holds 0 and clears its own enable bit; writing control with enable set restarts it from the load value.
- R12: Writes and events on one channel leave every other channel's registers and line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (4) | {channel, register index} |
| bus_wdata | input | CNT_W (32) | Write data |
| bus_rdata | output | CNT_W (32) | Registered read data |
| bus_rvalid | output | 1 | High the cycle after a read strobe |
| irq_o | output | NUM_CH (2) | Per-channel interrupt lines |

## Verification
A write takes effect at the edge that samples it, so a count written there is the value that edge leaves. A read returns the register as it stood just before the edge sampling the strobe, and the data appears one cycle later alongside the valid flag. After a write and n idle cycles, the count therefore reads back as the start value minus n. A zero event lands one tick after the counter shows 0, and the interrupt line moves on that same edge. The bench spends exactly one clock per bus task and queues each expected read word when the strobe is issued. The monitor compares the word on the returned valid cycle, and interrupt pins are sampled at the falling edge after the edge that should move them.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  typedef enum logic [1:0] {
    MODE_FREE        = 2'd0,
    MODE_PERIODIC    = 2'd1,
    MODE_ONESHOT     = 2'd2,
    MODE_ONESHOT_ALT = 2'd3
  } cdt_mode_e;

  localparam int REG_W     = 3;
  localparam int CTRL_BITS = 5;

  localparam logic [REG_W-1:0] REG_LOAD   = 3'd0;
  localparam logic [REG_W-1:0] REG_CTRL   = 3'd1;
  localparam logic [REG_W-1:0] REG_VALUE  = 3'd2;
  localparam logic [REG_W-1:0] REG_STATUS = 3'd3;
  localparam logic [REG_W-1:0] REG_CLEAR  = 3'd4;
endpackage

// File: rtl/cdt_channel.sv
module cdt_channel
  import cdt_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int NARROW_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_reg,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] load_o,
  output logic             en_o,
  output logic [1:0]       mode_o,
  output logic             wide_o,
  output logic             ie_o,
  output logic             stat_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] FULL_MASK   = '1;
  localparam logic [CNT_W-1:0] NARROW_MASK = {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [CNT_W-1:0] cnt_q, cnt_d, load_q, mask_q, mask_d;
  logic             en_q, en_d, wide_q, wide_d, ie_q, ie_d, stat_q, stat_d, irq_q;
  cdt_mode_e        mode_q, mode_d;
  logic             wr_load, wr_ctrl, wr_clr, zero_evt;

  assign wr_load = wr_en && (wr_reg == REG_LOAD);
  assign wr_ctrl = wr_en && (wr_reg == REG_CTRL);
  assign wr_clr  = wr_en && (wr_reg == REG_CLEAR) && wr_data[0];
  assign mask_q  = wide_q ? FULL_MASK : NARROW_MASK;

  always_comb begin
    en_d     = en_q;
    mode_d   = mode_q;
    wide_d   = wide_q;
    ie_d     = ie_q;
    cnt_d    = cnt_q;
    stat_d   = stat_q;
    zero_evt = 1'b0;
    if (wr_ctrl) begin
      en_d   = wr_data[0];
      mode_d = cdt_mode_e'(wr_data[2:1]);
      wide_d = wr_data[3];
      ie_d   = wr_data[4];
    end
    mask_d = wide_d ? FULL_MASK : NARROW_MASK;
    if (wr_ctrl) begin
      cnt_d = (mode_d == MODE_FREE) ? mask_d : (load_q & mask_d);
    end else if (wr_load && (mode_q != MODE_FREE)) begin
      cnt_d = wr_data & mask_q;
    end else if (en_q) begin
      if (cnt_q == '0) begin
        zero_evt = 1'b1;
        case (mode_q)
          MODE_FREE:     cnt_d = mask_q;
          MODE_PERIODIC: cnt_d = load_q & mask_q;
          default: begin
            cnt_d = '0;
            en_d  = 1'b0;
          end
        endcase
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
    if (wr_clr)   stat_d = 1'b0;
    if (zero_evt) stat_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= NARROW_MASK;
      load_q <= '0;
      en_q   <= 1'b0;
      mode_q <= MODE_FREE;
      wide_q <= 1'b0;
      ie_q   <= 1'b0;
      stat_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      if (wr_load) load_q <= wr_data;
      en_q   <= en_d;
      mode_q <= mode_d;
      wide_q <= wide_d;
      ie_q   <= ie_d;
      stat_q <= stat_d;
      irq_q  <= stat_d & ie_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign load_o = load_q;
  assign en_o   = en_q;
  assign mode_o = mode_q;
  assign wide_o = wide_q;
  assign ie_o   = ie_q;
  assign stat_o = stat_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/cdt_readmux.sv
module cdt_readmux
  import cdt_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32,
  parameter int CH_W   = 1
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  re,
  input  logic [CH_W-1:0]                       ch_sel,
  input  logic [REG_W-1:0]                      reg_sel,
  input  logic [NUM_CH-1:0][CNT_W-1:0]          cnt_a,
  input  logic [NUM_CH-1:0][CNT_W-1:0]          load_a,
  input  logic [NUM_CH-1:0][CTRL_BITS-1:0]      ctrl_a,
  input  logic [NUM_CH-1:0]                     stat_a,
  output logic [CNT_W-1:0]                      rdata,
  output logic                                  rvalid
);
  logic [CNT_W-1:0] word;

  always_comb begin
    word = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_sel == CH_W'(i)) begin
        case (reg_sel)
          REG_LOAD:   word = load_a[i];
          REG_CTRL:   word = {{(CNT_W-CTRL_BITS){1'b0}}, ctrl_a[i]};
          REG_VALUE:  word = cnt_a[i];
          REG_STATUS: word = {{(CNT_W-1){1'b0}}, stat_a[i]};
          default:    word = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= re;
      if (re) rdata <= word;
    end
  end
endmodule

// File: rtl/cfg_down_timer.sv
module cfg_down_timer
  import cdt_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int CNT_W    = 32,
  parameter int NARROW_W = 16,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W  = CH_W + REG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  output logic [NUM_CH-1:0] irq_o
);
  logic [NUM_CH-1:0][CNT_W-1:0]     cnt_a, load_a;
  logic [NUM_CH-1:0][CTRL_BITS-1:0] ctrl_a;
  logic [NUM_CH-1:0][1:0]           mode_a;
  logic [NUM_CH-1:0]                en_a, wide_a, ie_a, stat_a;
  logic [CH_W-1:0]                  ch_sel;
  logic [REG_W-1:0]                 reg_sel;

  assign ch_sel  = bus_addr[ADDR_W-1:REG_W];
  assign reg_sel = bus_addr[REG_W-1:0];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic sel_wr;
    assign sel_wr = bus_we && (ch_sel == CH_W'(g));

    cdt_channel #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_chan (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (sel_wr),
      .wr_reg (reg_sel),
      .wr_data(bus_wdata),
      .cnt_o  (cnt_a[g]),
      .load_o (load_a[g]),
      .en_o   (en_a[g]),
      .mode_o (mode_a[g]),
      .wide_o (wide_a[g]),
      .ie_o   (ie_a[g]),
      .stat_o (stat_a[g]),
      .irq_o  (irq_o[g])
    );

    assign ctrl_a[g] = {ie_a[g], wide_a[g], mode_a[g], en_a[g]};
  end

  cdt_readmux #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .CH_W(CH_W)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .re     (bus_re),
    .ch_sel (ch_sel),
    .reg_sel(reg_sel),
    .cnt_a  (cnt_a),
    .load_a (load_a),
    .ctrl_a (ctrl_a),
    .stat_a (stat_a),
    .rdata  (bus_rdata),
    .rvalid (bus_rvalid)
  );
endmodule

// File: rtl/cfg_down_timer_chk.sv
module cfg_down_timer_chk
  import cdt_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int CNT_W    = 32,
  parameter int NARROW_W = 16,
  parameter int CH_W     = 1,
  parameter int ADDR_W   = 4
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          bus_we,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic [CNT_W-1:0]              bus_wdata,
  input logic [NUM_CH-1:0][CNT_W-1:0]  cnt_a,
  input logic [NUM_CH-1:0][CNT_W-1:0]  load_a,
  input logic [NUM_CH-1:0][1:0]        mode_a,
  input logic [NUM_CH-1:0]             en_a,
  input logic [NUM_CH-1:0]             wide_a,
  input logic [NUM_CH-1:0]             ie_a,
  input logic [NUM_CH-1:0]             stat_a,
  input logic [NUM_CH-1:0]             irq_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    logic             hit_wr, clr_wr;
    logic [CNT_W-1:0] msk;
    assign hit_wr = bus_we && (bus_addr[ADDR_W-1:REG_W] == CH_W'(g));
    assign clr_wr = hit_wr && (bus_addr[REG_W-1:0] == REG_CLEAR) && bus_wdata[0];
    assign msk    = wide_a[g] ? '1 : {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    a_r2_free_wrap: assert property (@(posedge clk) disable iff (rst)
      (!hit_wr && en_a[g] && mode_a[g] == 2'd0 && cnt_a[g] == '0)
        |=> (cnt_a[g] == msk && stat_a[g]));

    a_r5_periodic_reload: assert property (@(posedge clk) disable iff (rst)
      (!hit_wr && en_a[g] && mode_a[g] == 2'd1 && cnt_a[g] == '0)
        |=> (cnt_a[g] == (load_a[g] & msk) && stat_a[g]));

    a_r11_oneshot_halt: assert property (@(posedge clk) disable iff (rst)
      (!hit_wr && en_a[g] && mode_a[g][1] && cnt_a[g] == '0)
        |=> (!en_a[g] && cnt_a[g] == '0 && stat_a[g]));

    a_r7_sticky_status: assert property (@(posedge clk) disable iff (rst)
      (stat_a[g] && !clr_wr) |=> stat_a[g]);

    a_r4_narrow_upper: assert property (@(posedge clk) disable iff (rst)
      !wide_a[g] |-> (cnt_a[g][CNT_W-1:NARROW_W] == '0));

    a_r8_line_needs_pass: assert property (@(posedge clk) disable iff (rst)
      irq_o[g] |-> (ie_a[g] && stat_a[g]));
  end
endmodule

bind cfg_down_timer cfg_down_timer_chk #(
  .NUM_CH(NUM_CH), .CNT_W(CNT_W), .NARROW_W(NARROW_W), .CH_W(CH_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .cnt_a(cnt_a), .load_a(load_a), .mode_a(mode_a), .en_a(en_a), .wide_a(wide_a),
  .ie_a(ie_a), .stat_a(stat_a), .irq_o(irq_o)
);

// File: tb/cfg_down_timer_test.sv
module cfg_down_timer_test;
  localparam int LOAD = 0, CTRL = 1, VAL = 2, STAT = 3, CLR = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [1:0]  irq_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  cfg_down_timer uut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq_o(irq_o)
  );

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] mk(input int ch, input int r);
    return {ch[0], r[2:0]};
  endfunction

  task automatic wr(input int ch, input int r, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = mk(ch, r); bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int ch, input int r, input logic [31:0] exp, input string tag);
    bus_re = 1'b1; bus_addr = mk(ch, r);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops the scoreboard on every returned read
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) cmp("unexpected read data", bus_rdata, 32'hx);
      else cmp(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    cmp("R1 irq lines after reset", {30'd0, irq_o}, 32'd0);
    rd(0, CTRL, 32'h0, "R1 control reset");
    rd(0, VAL, 32'h0000FFFF, "R1 count reset");
    rd(1, STAT, 32'h0, "R1 status reset");

    // R2 free-running 16-bit with pass enabled
    wr(0, CTRL, 32'h11);
    idle(9);
    rd(0, VAL, 32'h0000FFF6, "R2 free count after 9 ticks");
    wr(0, CTRL, 32'h11);
    idle(65535);
    rd(0, VAL, 32'h0, "R2 free reaches zero");
    cmp("R8 line raised with pass", {31'd0, irq_o[0]}, 32'd1);
    rd(0, STAT, 32'h1, "R2 status after wrap");
    rd(0, VAL, 32'h0000FFFE, "R2 restart from all-ones");

    // R3 32-bit free-running, pass off
    wr(0, CTRL, 32'h09);
    idle(4);
    rd(0, VAL, 32'hFFFFFFFB, "R3 wide free count");
    cmp("R8 line low when masked", {31'd0, irq_o[0]}, 32'd0);
    // R9 load write ignored in free mode
    wr(0, LOAD, 32'd100);
    rd(0, VAL, 32'hFFFFFFF9, "R9 free count undisturbed");

    // R6 load write restarts periodic count
    wr(0, CTRL, 32'h0B);
    idle(10);
    rd(0, VAL, 32'd90, "R6 periodic from load");
    wr(0, LOAD, 32'd7);
    rd(0, VAL, 32'd7, "R6 restart on load write");

    // R11 one-shot
    wr(0, CLR, 32'h1);
    wr(0, CTRL, 32'h1D);
    idle(10);
    rd(0, VAL, 32'd0, "R11 one-shot holds zero");
    rd(0, CTRL, 32'h1C, "R11 enable self-cleared");
    rd(0, STAT, 32'h1, "R11 status set");
    idle(5);
    rd(0, VAL, 32'd0, "R11 still halted");
    cmp("R11 line for one-shot", {31'd0, irq_o[0]}, 32'd1);
    wr(0, CTRL, 32'h1D);
    idle(2);
    rd(0, VAL, 32'd5, "R11 re-arm restarts");
    wr(0, CTRL, 32'h1C);

    // R4 narrow load, R5 periodic
    wr(1, CTRL, 32'h02);
    wr(1, LOAD, 32'h00120005);
    rd(1, VAL, 32'd5, "R4 low 16 bits of load only");
    wr(1, CTRL, 32'h13);
    idle(5);
    rd(1, VAL, 32'd0, "R5 periodic reaches zero");
    cmp("R8 line ch1 raised", {31'd0, irq_o[1]}, 32'd1);
    rd(1, VAL, 32'd5, "R5 periodic reload");
    idle(2);
    rd(1, STAT, 32'h1, "R7 status sticky");
    wr(1, CLR, 32'h1);
    rd(1, STAT, 32'h0, "R7 clear by write 1");

    // R10 zero load, R8 masked, R7 set wins over clear
    wr(1, CTRL, 32'h02);
    wr(1, CLR, 32'h1);
    wr(1, CTRL, 32'h03);
    wr(1, LOAD, 32'h0);
    idle(1);
    rd(1, STAT, 32'h1, "R10 event on first tick");
    cmp("R8 line masked ch1", {31'd0, irq_o[1]}, 32'd0);
    wr(1, CLR, 32'h1);
    rd(1, STAT, 32'h1, "R7 event beats clear");
    rd(1, VAL, 32'd0, "R10 reloads zero each tick");

    // R12 channel independence
    wr(0, CLR, 32'h1);
    idle(3);
    rd(0, STAT, 32'h0, "R12 ch0 status unaffected by ch1");
    rd(0, VAL, 32'd7, "R12 ch0 count unaffected");
    rd(1, CTRL, 32'h03, "R12 ch1 control unchanged");

    idle(3);
    if (exp_q.size() != 0) cmp("R12 pending reads drained", exp_q.size(), 32'd0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule